// File: doc/BRIEF.md
# Packed-Pixel Video Fetch Pipeline

This block sits between a byte-wide video memory and the colour outputs of a raster display. It receives the horizontal pixel counter, the vertical line counter and a blanking flag from an external timing generator. It forms a memory address from those counters and reads one byte that holds four 2-bit pixels. It shifts those pixels out one per pixel clock, least significant pair first. Each pixel is turned into one of four fixed colours on three registered gun-control bits. Sync generation and the counters themselves live outside.

The memory is used as read-only storage: the select strobe is always active, the write strobe is never active, and the read strobe drops while the display is blanked. Blanking passes through one register stage, so it lines up with the pixel held in the shift register. The colour register is then forced to black for that pixel.

Top module: `vid_pix_fetch`

## Requirements
- R1: `mem_addr[14:6]` equals `ln_cnt[8:0]` and `mem_addr[5:0]` equals `px_cnt[7:2]`. Line counter bit 9 and pixel counter bits 9, 8, 1 and 0 do not affect the address.
- R2: `mem_sel` is always 1 and `mem_wr_en` is always 0. Both strobes are active high.
- R3: `mem_rd_en` (active high) is the inverse of `blank_in` in the same cycle.
- R4: At a rising edge where `px_cnt[1:0]` is 00, the pixel word register loads `mem_rdata` as it stands before that edge.
- R5: At every other rising edge, the pixel word shifts right by two bits and fills with zeros. The active pixel is word bits 1:0, so a loaded byte shows its bits 1:0, then 3:2, then 5:4, then 7:6 on the next four edges.
- R6: `blank_in` is registered once. If `blank_in` was 1 in the cycle before the edge that loads `rgb`, then `rgb` becomes 3'b000.
- R7: Otherwise `rgb` = {red, green, blue} loads the colour of the active pixel: code 00 gives 3'b100, 01 gives 3'b010, 10 gives 3'b001 and 11 gives 3'b111.
- R8: Reset is synchronous and active high, at the rising edge. It clears `rgb` and the pixel word, and it sets the blanking stage to blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| px_cnt | input | 10 | Horizontal pixel counter |
| ln_cnt | input | 10 | Vertical line counter |
| blank_in | input | 1 | Blanking flag, 1 = outside the visible area |
| mem_rdata | input | 8 | Data byte from video memory |
| mem_addr | output | 15 | Video memory byte address |
| mem_sel | output | 1 | Memory select, active high |
| mem_wr_en | output | 1 | Memory write strobe, active high |
| mem_rd_en | output | 1 | Memory read/output strobe, active high |
| rgb | output | 3 | Registered gun bits {red, green, blue} |

## Verification
The pixel path is run with the counter sweeping one whole line and past its wrap. The memory model returns a different mix of pixel codes in every byte. A wrong shift direction, a wrong load phase or a swapped palette entry therefore shows up as a wrong colour at a known pixel. A second run switches blanking on and off in an irregular pattern. A black pixel must then follow exactly one cycle after each blanked cycle, and the read strobe must follow blanking in the same cycle, which exposes a missing or doubled delay stage. Counter values with the unused high and low bits set show whether those bits leak into the address. A reset followed by a non-load phase shows the cleared word as code 00, which is red.

// File: rtl/vid_pix_fetch_pkg.sv
package vid_pix_fetch_pkg;

   typedef logic [2:0] gun_t;   // {red, green, blue}

   localparam gun_t GUN_BLACK = 3'b000;
   localparam gun_t GUN_RED   = 3'b100;
   localparam gun_t GUN_GREEN = 3'b010;
   localparam gun_t GUN_BLUE  = 3'b001;
   localparam gun_t GUN_WHITE = 3'b111;

   // fixed four-entry palette
   function automatic gun_t pal_lookup(input logic [1:0] code);
      case (code)
         2'b00:   pal_lookup = GUN_RED;
         2'b01:   pal_lookup = GUN_GREEN;
         2'b10:   pal_lookup = GUN_BLUE;
         default: pal_lookup = GUN_WHITE;
      endcase
   endfunction

endpackage

// File: rtl/vid_pix_addr_gen.sv
module vid_pix_addr_gen #(
   parameter int PXC_W   = 10,
   parameter int LNC_W   = 10,
   parameter int PAGE_AW = 9,
   parameter int COL_AW  = 6,
   parameter int SEL_W   = 2,
   localparam int ADDR_W = PAGE_AW + COL_AW
) (
   input  logic [PXC_W-1:0]  px_cnt,
   input  logic [LNC_W-1:0]  ln_cnt,
   output logic [ADDR_W-1:0] addr
);

   if (PAGE_AW > LNC_W) begin : g_bad_page
      $error("vid_pix_addr_gen: PAGE_AW exceeds line counter width");
   end
   if (SEL_W + COL_AW > PXC_W) begin : g_bad_col
      $error("vid_pix_addr_gen: column field exceeds pixel counter width");
   end

   // page from the line counter, byte-in-page from the pixel counter above the pixel-select bits
   assign addr = {ln_cnt[PAGE_AW-1:0], px_cnt[SEL_W +: COL_AW]};

endmodule

// File: rtl/vid_pix_shreg.sv
module vid_pix_shreg #(
   parameter int BYTE_W = 8,
   parameter int PIX_W  = 2,
   localparam int NSLOT = BYTE_W / PIX_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [BYTE_W-1:0] din,
   output logic [BYTE_W-1:0] word,
   output logic [PIX_W-1:0]  pix
);

   logic [BYTE_W-1:0] word_q;
   logic [BYTE_W-1:0] shifted;

   // each slot takes its upper neighbour; the top slot fills with zero
   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      if (i == NSLOT - 1) begin : g_top
         assign shifted[i*PIX_W +: PIX_W] = '0;
      end else begin : g_mid
         assign shifted[i*PIX_W +: PIX_W] = word_q[(i+1)*PIX_W +: PIX_W];
      end
   end

   always_ff @(posedge clk) begin
      if (rst)       word_q <= '0;
      else if (load) word_q <= din;
      else           word_q <= shifted;
   end

   assign word = word_q;
   assign pix  = word_q[PIX_W-1:0];

endmodule

// File: rtl/vid_pix_colour.sv
module vid_pix_colour
   import vid_pix_fetch_pkg::*;
#(
   parameter int PIX_W  = 2,
   localparam int NCODE = 1 << PIX_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             blank_in,
   input  logic [PIX_W-1:0] pix,
   output gun_t             rgb
);

   gun_t pal [NCODE];
   logic blank_q;
   gun_t rgb_q;

   for (genvar c = 0; c < NCODE; c++) begin : g_pal
      assign pal[c] = pal_lookup(2'(c));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         blank_q <= 1'b1;
         rgb_q   <= GUN_BLACK;
      end else begin
         blank_q <= blank_in;
         rgb_q   <= blank_q ? GUN_BLACK : pal[pix];
      end
   end

   assign rgb = rgb_q;

endmodule

// File: rtl/vid_pix_fetch.sv
module vid_pix_fetch #(
   parameter int PXC_W   = 10,
   parameter int LNC_W   = 10,
   parameter int BYTE_W  = 8,
   parameter int PIX_W   = 2,
   parameter int PAGE_AW = 9,
   parameter int COL_AW  = 6,
   localparam int PIX_PER_BYTE = BYTE_W / PIX_W,
   localparam int SEL_W  = $clog2(PIX_PER_BYTE),
   localparam int ADDR_W = PAGE_AW + COL_AW
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PXC_W-1:0]  px_cnt,
   input  logic [LNC_W-1:0]  ln_cnt,
   input  logic              blank_in,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_sel,
   output logic              mem_wr_en,
   output logic              mem_rd_en,
   output logic [2:0]        rgb
);

   if (PIX_W != 2) begin : g_bad_pix
      $error("vid_pix_fetch: the fixed palette needs 2-bit pixels");
   end
   if (BYTE_W % PIX_W != 0) begin : g_bad_pack
      $error("vid_pix_fetch: BYTE_W must be a multiple of PIX_W");
   end
   if ((1 << SEL_W) != PIX_PER_BYTE) begin : g_bad_pow2
      $error("vid_pix_fetch: pixels per byte must be a power of two");
   end

   logic              load;
   logic [BYTE_W-1:0] pix_word;
   logic [PIX_W-1:0]  pix_act;

   vid_pix_addr_gen #(
      .PXC_W(PXC_W), .LNC_W(LNC_W), .PAGE_AW(PAGE_AW),
      .COL_AW(COL_AW), .SEL_W(SEL_W)
   ) i_addr (
      .px_cnt(px_cnt), .ln_cnt(ln_cnt), .addr(mem_addr)
   );

   // memory used as read-only storage
   assign mem_sel   = 1'b1;
   assign mem_wr_en = 1'b0;
   assign mem_rd_en = ~blank_in;

   assign load = (px_cnt[SEL_W-1:0] == '0);

   vid_pix_shreg #(.BYTE_W(BYTE_W), .PIX_W(PIX_W)) i_shreg (
      .clk(clk), .rst(rst), .load(load), .din(mem_rdata),
      .word(pix_word), .pix(pix_act)
   );

   vid_pix_colour #(.PIX_W(PIX_W)) i_colour (
      .clk(clk), .rst(rst), .blank_in(blank_in), .pix(pix_act), .rgb(rgb)
   );

endmodule

// File: rtl/vid_pix_fetch_chk.sv
module vid_pix_fetch_chk #(
   parameter int BYTE_W = 8,
   parameter int SEL_W  = 2,
   parameter int PIX_W  = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              blank_in,
   input logic [SEL_W-1:0]  px_lo,
   input logic [BYTE_W-1:0] mem_rdata,
   input logic              mem_sel,
   input logic              mem_wr_en,
   input logic              mem_rd_en,
   input logic [2:0]        rgb,
   input logic [BYTE_W-1:0] pix_word
);

   p_rom_mode_r2: assert property (@(posedge clk) disable iff (rst)
      mem_sel && !mem_wr_en);

   p_rd_gate_r3: assert property (@(posedge clk) disable iff (rst)
      mem_rd_en != blank_in);

   p_load_r4: assert property (@(posedge clk) disable iff (rst)
      (px_lo == '0) |=> (pix_word == $past(mem_rdata)));

   p_shift_r5: assert property (@(posedge clk) disable iff (rst)
      (px_lo != '0) |=> (pix_word == ($past(pix_word) >> PIX_W)));

   p_black_r6: assert property (@(posedge clk) disable iff (rst)
      $past(blank_in, 2) |-> (rgb == 3'b000));

   p_palette_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(rgb) || (rgb == 3'b111));

   p_clear_r8: assert property (@(posedge clk)
      rst |=> ((rgb == 3'b000) && (pix_word == '0)));

endmodule

bind vid_pix_fetch vid_pix_fetch_chk #(
   .BYTE_W(BYTE_W), .SEL_W(SEL_W), .PIX_W(PIX_W)
) i_chk (
   .clk(clk), .rst(rst), .blank_in(blank_in), .px_lo(px_cnt[SEL_W-1:0]),
   .mem_rdata(mem_rdata), .mem_sel(mem_sel), .mem_wr_en(mem_wr_en),
   .mem_rd_en(mem_rd_en), .rgb(rgb), .pix_word(pix_word)
);

// File: tb/test_vid_pix_fetch.sv
`timescale 1ns/1ps
module test_vid_pix_fetch;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [9:0]  px_cnt = '0;
   logic [9:0]  ln_cnt = '0;
   logic        blank_in = 1'b1;
   logic [7:0]  mem_rdata = '0;
   logic [14:0] mem_addr;
   logic        mem_sel, mem_wr_en, mem_rd_en;
   logic [2:0]  rgb;

   int n_chk  = 0;
   int n_fail = 0;

   // history of driven inputs, one entry per cycle of a run
   logic [14:0] h_addr  [0:511];
   logic [9:0]  h_px    [0:511];
   logic        h_blank [0:511];

   always #5 clk = ~clk;

   vid_pix_fetch i_vid_pix_fetch (
      .clk(clk), .rst(rst), .px_cnt(px_cnt), .ln_cnt(ln_cnt),
      .blank_in(blank_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
      .mem_sel(mem_sel), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
      .rgb(rgb)
   );

   // memory contents computed from the address
   function automatic logic [7:0] mem_fn(input logic [14:0] a);
      logic [7:0] m;
      m = a[7:0] * 8'd29;
      return m ^ a[14:7] ^ 8'h5A;
   endfunction

   // behavioural memory, one pixel clock read latency
   always_ff @(posedge clk) mem_rdata <= mem_fn(mem_addr);

   function automatic logic [2:0] ref_colour(input logic [1:0] code);
      case (code)
         2'd0: return 3'b100;
         2'd1: return 3'b010;
         2'd2: return 3'b001;
         default: return 3'b111;
      endcase
   endfunction

   function automatic logic [14:0] ref_addr(input logic [9:0] ln, input logic [9:0] px);
      return {ln[8:0], px[7:2]};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; blank_in = 1'b0; px_cnt = 10'd0;
      @(negedge clk);
      @(negedge clk);
   endtask

   // checks rgb after edge e of the current run
   task automatic check_edge(input int e);
      logic [2:0] exp;
      int j;
      if (e < 1) return;
      if (h_blank[e-1]) begin
         chk(rgb == 3'b000, "R6 blank forces black", 32'(rgb), 32'(0));
         return;
      end
      j = e - 1;
      while (j >= 1 && h_px[j][1:0] != 2'b00) j--;
      if (j < 1 || (e - 1 - j) > 3) return;
      exp = ref_colour(2'((mem_fn(h_addr[j-1]) >> (2 * (e - 1 - j)))));
      chk(rgb == exp, "R4 R5 R7 pixel colour", 32'(rgb), 32'(exp));
   endtask

   task automatic run_seq(input logic [9:0] ln, input logic [9:0] px0, input int n, input int bmode);
      for (int t = 0; t < n; t++) begin
         @(negedge clk);
         if (t > 0) check_edge(t - 1);
         ln_cnt   = ln;
         px_cnt   = px0 + 10'(t);
         blank_in = (bmode == 0) ? 1'b0 : ((t % 7 == 3) || (t % 5 == 0) || (t > 200 && t < 212));
         h_px[t]    = px_cnt;
         h_addr[t]  = ref_addr(ln, px_cnt);
         h_blank[t] = blank_in;
         #1;
         chk(mem_addr == h_addr[t], "R1 address", 32'(mem_addr), 32'(h_addr[t]));
         chk(mem_rd_en == !blank_in, "R3 read strobe", 32'(mem_rd_en), 32'(!blank_in));
         chk(mem_sel == 1'b1 && mem_wr_en == 1'b0, "R2 strobes", {mem_sel, mem_wr_en}, 32'b10);
      end
      @(negedge clk);
      check_edge(n - 1);
   endtask

   task automatic test_reset();
      @(negedge clk);
      rst = 1'b1; blank_in = 1'b0; px_cnt = 10'd1;
      @(negedge clk);
      chk(rgb == 3'b000, "R8 rgb cleared", 32'(rgb), 32'(0));
      rst = 1'b0; blank_in = 1'b0; px_cnt = 10'd1;
      @(negedge clk);
      chk(rgb == 3'b000, "R8 blank stage set after reset", 32'(rgb), 32'(0));
      px_cnt = 10'd2;
      @(negedge clk);
      chk(rgb == 3'b100, "R8 cleared word gives red", 32'(rgb), 32'(3'b100));
   endtask

   task automatic test_addr();
      logic [9:0] lns [0:3];
      logic [9:0] pxs [0:3];
      lns = '{10'h000, 10'h3FF, 10'h155, 10'h200};
      pxs = '{10'h000, 10'h3FF, 10'h103, 10'h2AA};
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         ln_cnt = lns[k]; px_cnt = pxs[k]; blank_in = k[0];
         #1;
         chk(mem_addr == ref_addr(lns[k], pxs[k]), "R1 unused bits ignored", 32'(mem_addr), 32'(ref_addr(lns[k], pxs[k])));
         chk(mem_rd_en == !blank_in, "R3 read strobe", 32'(mem_rd_en), 32'(!blank_in));
         chk(mem_sel && !mem_wr_en, "R2 read-only", {mem_sel, mem_wr_en}, 32'b10);
      end
   endtask

   task automatic test_stream();
      do_reset();
      rst = 1'b0;
      run_seq(10'd3, 10'd1022, 300, 0);
      do_reset();
      rst = 1'b0;
      run_seq(10'h3FF, 10'd0, 80, 0);
   endtask

   task automatic test_blank();
      do_reset();
      rst = 1'b0;
      run_seq(10'd77, 10'd5, 260, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R5 actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      test_addr();
      test_stream();
      test_blank();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule